// File: doc/BRIEF.md
# DMA Completion Interrupt Register

This block is the interrupt control word of a multi-channel DMA engine, presented as a single 32-bit register. It stores one completion-interrupt enable per channel, a global enable, a software-forced bus-error bit and six general control bits. It also holds one completion flag per channel and a master flag that summarises them. The transfer engines pulse `ch_done_i` when a channel finishes. The register records the event if that channel is enabled. It then drives a single-cycle request toward the system interrupt controller when the master flag goes from clear to set.

Software writes the whole word in one cycle. Control bits take the written value directly. Completion flags are acknowledged by writing ones to them. The master flag cannot be written: it is recomputed every cycle from the register's next contents. Because of this, acknowledging every pending flag (or dropping the enables) lets it fall, and the next completion raises a fresh request.

Top module: `dma_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low the register reads 0x00000000 and `irq_o` is low.
- R2: On a write, the bits under mask 0x00FF803F (bits 0-5, bit 15 bus error, bits 16-22 channel enables for channels 0-6, bit 23 global enable) take the written value in the next cycle. Bits 6-14 always read 0.
- R3: A `ch_done_i[n]` pulse sets flag bit 24+n in the next cycle only if enable bit 16+n is set in the register before that edge. When the enable is clear, the pulse has no effect.
- R4: Writing 1 to flag bit 24+n clears that flag and writing 0 keeps it. If a completion and an acknowledge of the same channel fall in the same cycle, the flag ends set.
- R5: Bit 31 reads 1 exactly when (bit 23 and any of bits 24-30) or bit 15 holds in the same read value.
- R6: `irq_o` is high for one cycle, in the cycle where bit 31 first reads 1 after having read 0. It stays low while bit 31 remains set.
- R7: After bit 31 has been cleared, a later event that makes the master condition true again raises a new `irq_o` pulse.
- R8: Written values of bits 24-31 never set those bits. A 1 there only acts as an acknowledge (bits 24-30) or is ignored (bit 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| ch_done_i | input | NUM_CH | Per-channel transfer-complete pulses |
| rd_data_o | output | 32 | Current register value |
| irq_o | output | 1 | Single-cycle interrupt request |

## Verification
The hardest state to reach is a second interrupt pulse after the master flag has already fired. Reaching it needs the flag to fall first, and that requires a write that acknowledges every pending enabled flag while leaving the global enable set. The stimulus raises two channel flags and acknowledges them one at a time. It confirms that bit 31 holds after the first acknowledge and falls after the second, then completes a channel again to draw the new pulse. A same-cycle completion and acknowledge on one channel is also driven, to show that the set takes priority.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned MAX_CH    = 7;
  localparam int unsigned BERR_BIT  = 15;
  localparam int unsigned EN_LSB    = 16;
  localparam int unsigned GEN_BIT   = 23;
  localparam int unsigned FLG_LSB   = 24;
  localparam int unsigned MFLAG_BIT = 31;
  localparam logic [REG_W-1:0] WR_MASK = 32'h00FF_803F;
endpackage

// File: rtl/icr_flag_cell.sv
module icr_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_nxt_o,
  output logic flag_o
);
  logic flag_q;

  // set has priority over acknowledge
  assign flag_nxt_o = (flag_q & ~clr_i) | (done_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;

  // R3
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && en_i) |=> flag_o);

  // R4
  flag_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  // R3
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !(done_i && en_i)) |=> !flag_o);
endmodule

// File: rtl/icr_master.sv
module icr_master #(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_nxt_i,
  input  logic              berr_nxt_i,
  input  logic [NUM_CH-1:0] flags_nxt_i,
  output logic              mflag_o,
  output logic              irq_o
);
  logic cond_nxt;
  logic mflag_q, irq_q;

  assign cond_nxt = (gen_nxt_i & (|flags_nxt_i)) | berr_nxt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mflag_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      mflag_q <= cond_nxt;
      irq_q   <= cond_nxt & ~mflag_q;
    end
  end

  assign mflag_o = mflag_q;
  assign irq_o   = irq_q;

  // R6
  irq_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R6
  irq_with_mflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mflag_o);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NUM_CH-1:0] ch_done_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  localparam int unsigned FLG_W = MAX_CH;

  logic [REG_W-1:0]  ctrl_q, ctrl_nxt;
  logic [NUM_CH-1:0] flags_q, flags_nxt;
  logic [FLG_W-1:0]  flags_ext;
  logic              mflag;

  assign ctrl_nxt = wr_en_i ? (wr_data_i & WR_MASK) : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_nxt;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    icr_flag_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .done_i     (ch_done_i[n]),
      .en_i       (ctrl_q[EN_LSB+n]),
      .clr_i      (wr_en_i & wr_data_i[FLG_LSB+n]),
      .flag_nxt_o (flags_nxt[n]),
      .flag_o     (flags_q[n])
    );
  end

  icr_master #(.NUM_CH(NUM_CH)) u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gen_nxt_i   (ctrl_nxt[GEN_BIT]),
    .berr_nxt_i  (ctrl_nxt[BERR_BIT]),
    .flags_nxt_i (flags_nxt),
    .mflag_o     (mflag),
    .irq_o       (irq_o)
  );

  assign flags_ext = FLG_W'(flags_q);

  always_comb begin
    rd_data_o = ctrl_q;
    rd_data_o[FLG_LSB +: FLG_W] = flags_ext;
    rd_data_o[MFLAG_BIT] = mflag;
  end

  initial begin
    if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range");
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[14:6] == 9'd0);

  // R5
  berr_forces_master_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BERR_BIT] |-> rd_data_o[MFLAG_BIT]);

  // R5
  master_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[MFLAG_BIT] && !wr_en_i) |=> rd_data_o[MFLAG_BIT]);

  // R2
  ctrl_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[23:0]));
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
  localparam int NCH = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [31:0]    wr_data = '0;
  logic [NCH-1:0] done = '0;
  logic [31:0]    rd_data;
  logic           irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_reg = '0;
  logic        exp_irq = 1'b0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ch_done_i(done), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic check(string tag);
    checks++;
    if (rd_data !== exp_reg) begin
      errors++;
      $display("FAIL %s reg actual %08h expected %08h", tag, rd_data, exp_reg);
    end
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp_irq);
    end
  endtask

  // one clock: drive, let the model advance at the edge, compare at negedge
  task automatic step(string tag, bit w, logic [31:0] d, logic [NCH-1:0] dn);
    logic [31:0] ctrl;
    logic [6:0]  fl;
    bit          cond;
    wr_en = w; wr_data = d; done = dn;
    @(posedge clk);
    ctrl = w ? (d & 32'h00FF803F) : (exp_reg & 32'h00FF803F);
    fl = exp_reg[30:24];
    if (w) fl = fl & ~d[30:24];
    fl = fl | (7'(dn) & exp_reg[22:16]);
    cond = (ctrl[23] && fl != 0) || ctrl[15];
    exp_irq = cond && !exp_reg[31];
    exp_reg = ctrl | {1'b0, fl, 24'd0} | {cond, 31'd0};
    @(negedge clk);
    check(tag);
    wr_en = 1'b0; done = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step("R1", 0, 0, 0);
    // all ones: masked bits only, berr forces master, first pulse
    step("R8", 1, 32'hFFFF_FFFF, 0);
    step("R6", 0, 0, 0);
    step("R5", 1, 32'h0000_0000, 0);
    step("R2", 1, 32'h0000_002A, 0);
    step("R2", 1, 32'h0000_7FC0, 0);
    // enables ch0 and ch3 only, no global enable
    step("R2", 1, 32'h0009_0000, 0);
    step("R3", 0, 0, 7'h7F);
    step("R3", 0, 0, 7'h04);
    // global enable on, flags kept (zeros written to flag bits)
    step("R5", 1, 32'h0089_0000, 0);
    step("R6", 0, 0, 7'h09);
    step("R6", 0, 0, 0);
    // acknowledge ch0: ch3 pending, master stays
    step("R4", 1, 32'h0189_0000, 0);
    step("R4", 0, 0, 0);
    // acknowledge ch3: master falls
    step("R4", 1, 32'h0889_0000, 0);
    step("R7", 0, 0, 0);
    step("R7", 0, 0, 7'h08);
    step("R7", 0, 0, 0);
    // same-cycle completion and acknowledge on ch3
    step("R4", 1, 32'h0889_0000, 7'h08);
    step("R4", 0, 0, 0);
    // write 1 to bit 31 while clearing all: ignored
    step("R8", 1, 32'hFF89_0000, 0);
    step("R8", 0, 0, 0);
    // berr alone raises a pulse, then clears
    step("R5", 1, 32'h0000_8000, 0);
    step("R5", 1, 32'h0000_0000, 0);
    // disabled channel completes: nothing happens
    step("R3", 1, 32'h0080_0000, 7'h7F);
    step("R3", 0, 0, 0);
    // reset mid-run
    rst_n = 1'b0;
    exp_reg = '0; exp_irq = 1'b0;
    #1;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 0, 0, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule